// File: doc/BRIEF.md
# PHY Register Handshake Sequencer

This block gives a host a simple request port for reading and writing 16-bit PHY registers that sit behind a strobe-and-acknowledge port rather than on a memory bus. The host presents an operation, an address and, for writes, a data word, and pulses a start input. The block turns that request into a chain of four-phase handshakes on a 20-bit control word. It watches a single acknowledge bit in a 17-bit status word.

Every access begins by capturing the address. A write then captures the data and fires a write strobe. A read fires a read strobe and samples the status data field while the acknowledge is high. Each strobe step waits first for the acknowledge to rise and then for it to fall. The acknowledge is polled at an interval set by a clock prescaler, and the poll count is bounded. If the PHY stops answering, the access is abandoned, the control word returns to zero and a one-cycle error is raised.

Top module: `phy_handshake_master`

## Requirements
- R1: Control word layout: field [15:0] carries address or data, capture-address is bit 16, capture-data is bit 17, write is bit 18, read is bit 19. Status word layout: read data in [15:0], acknowledge at bit 16. At most one of bits 19:16 is set at any time.
- R2: Every access starts with an address phase on the control word: address alone, then address with capture-address, then after ack=1 the address alone, then a wait for ack=0.
- R3: A write continues with data alone, data with capture-data, then after ack=1 data alone, then after ack=0 the write strobe alone. After ack=1 it drives data alone, and after ack=0 the control word goes to zero and the access completes.
- R4: A read continues with the read strobe alone. When ack=1 is seen, status bits [15:0] are captured into the read-data output and the control word goes to zero. After ack=0 the access completes.
- R5: Each acknowledge wait polls on its first cycle and then once every PRESCALE clock cycles. It moves on at the first poll that sees the expected level. A strobe never drops before the acknowledge has been seen high.
- R6: When MAX_POLLS polls in one wait all miss, the access ends at once: the error output pulses for one cycle, done does not pulse, and the control word is zero. With no acknowledge at all, the error appears 2+(MAX_POLLS-1)*PRESCALE cycles after the start is sampled. With the acknowledge stuck high, it appears one cycle later.
- R7: Done pulses high for exactly one cycle per successful access. The read-data output changes only when a read captures status data; it holds through idle time and through writes.
- R8: A start pulse that arrives while an access is in progress is ignored. The running access completes unchanged, and no second access follows.
- R9: During and after reset the control word is zero and done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | One-cycle pulse on successful completion |
| req_err | output | 1 | One-cycle pulse on acknowledge timeout |
| req_rdata | output | 16 | Data captured by the last successful read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
A behavioural PHY answers each strobe with an acknowledge delayed by a per-access latency. The latency ranges from one cycle to three poll intervals, so both the immediate-hit path and the multi-poll path are exercised. Writes and reads are interleaved to the same and to different addresses, and each read is compared with a bench-side model of the PHY contents; this shows that the address and data reached the PHY in the right phases. The full control-word sequence is logged and compared word by word. Two stuck patterns, acknowledge never rising and acknowledge never falling, are told apart by their exact error latency. A second start injected mid-access checks that a busy request is ignored.

// File: rtl/phyhs_pkg.sv
package phyhs_pkg;
  localparam int FIELD_W  = 16;
  localparam int CAPA_BIT = 16;
  localparam int CAPD_BIT = 17;
  localparam int WR_BIT   = 18;
  localparam int RD_BIT   = 19;
  localparam int CTRL_W   = 20;
  localparam int ACK_BIT  = 16;
  localparam int STAT_W   = 17;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_SET,
    ST_ADR_CAP,
    ST_ADR_REL,
    ST_DAT_SET,
    ST_DAT_CAP,
    ST_DAT_REL,
    ST_WR_ON,
    ST_WR_REL,
    ST_RD_ON,
    ST_RD_REL
  } seq_state_e;
endpackage

// File: rtl/phyhs_prescaler.sv
module phyhs_prescaler #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [CNT_W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (restart)
          cnt_d = '0;
        else if (run)
          cnt_d = (cnt_q == CNT_W'(DIV-1)) ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = run && (cnt_q == '0);

      // R5: the interval counter stays inside its divide range
      a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DIV-1));
    end else begin : g_pass
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/phyhs_ack_poller.sv
module phyhs_ack_poller #(
  parameter int MAX_POLLS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic ack,
  input  logic expect_hi,
  output logic hit,
  output logic expired
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [PW-1:0] poll_q, poll_d;
  logic          match, last;

  assign match   = (ack == expect_hi);
  assign last    = (poll_q == PW'(MAX_POLLS-1));
  assign hit     = tick && match;
  assign expired = tick && !match && last;

  always_comb begin
    poll_d = poll_q;
    if (restart)
      poll_d = '0;
    else if (tick && !match && !last)
      poll_d = poll_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) poll_q <= '0;
    else        poll_q <= poll_d;
  end

  // R6: the miss counter never passes the last allowed poll
  a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= PW'(MAX_POLLS-1));
endmodule

// File: rtl/phy_handshake_master.sv
module phy_handshake_master
  import phyhs_pkg::*;
#(
  parameter int PRESCALE  = 100,
  parameter int MAX_POLLS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_start,
  input  logic               req_write,
  input  logic [FIELD_W-1:0] req_addr,
  input  logic [FIELD_W-1:0] req_wdata,
  output logic               req_done,
  output logic               req_err,
  output logic [FIELD_W-1:0] req_rdata,
  output logic [CTRL_W-1:0]  phy_ctrl,
  input  logic [STAT_W-1:0]  phy_stat
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  seq_state_e         state_q, state_d;
  logic               write_q;
  logic [FIELD_W-1:0] addr_q, wdata_q, rdata_q;
  logic               done_q, err_q;
  logic               accept, waiting, expect_hi, restart;
  logic               tick, hit, expired;
  logic               rd_capture, done_d;

  assign accept = (state_q == ST_IDLE) && req_start;

  always_comb begin
    waiting   = 1'b1;
    expect_hi = 1'b0;
    unique case (state_q)
      ST_ADR_CAP, ST_DAT_CAP, ST_WR_ON, ST_RD_ON: expect_hi = 1'b1;
      ST_ADR_REL, ST_DAT_REL, ST_WR_REL, ST_RD_REL: expect_hi = 1'b0;
      default: waiting = 1'b0;
    endcase
  end

  phyhs_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n_i), .restart(restart), .run(waiting), .tick(tick)
  );

  phyhs_ack_poller #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n_i), .restart(restart), .tick(tick),
    .ack(phy_stat[ACK_BIT]), .expect_hi(expect_hi),
    .hit(hit), .expired(expired)
  );

  always_comb begin
    state_d = state_q;
    if (expired) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:    if (req_start) state_d = ST_ADR_SET;
        ST_ADR_SET: state_d = ST_ADR_CAP;
        ST_ADR_CAP: if (hit) state_d = ST_ADR_REL;
        ST_ADR_REL: if (hit) state_d = write_q ? ST_DAT_SET : ST_RD_ON;
        ST_DAT_SET: state_d = ST_DAT_CAP;
        ST_DAT_CAP: if (hit) state_d = ST_DAT_REL;
        ST_DAT_REL: if (hit) state_d = ST_WR_ON;
        ST_WR_ON:   if (hit) state_d = ST_WR_REL;
        ST_WR_REL:  if (hit) state_d = ST_IDLE;
        ST_RD_ON:   if (hit) state_d = ST_RD_REL;
        ST_RD_REL:  if (hit) state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  assign restart    = (state_d != state_q);
  assign rd_capture = (state_q == ST_RD_ON) && hit;
  assign done_d     = hit && ((state_q == ST_WR_REL) || (state_q == ST_RD_REL));

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= expired;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)        rdata_q <= '0;
    else if (rd_capture) rdata_q <= phy_stat[FIELD_W-1:0];
  end

  always_comb begin
    phy_ctrl = '0;
    unique case (state_q)
      ST_ADR_SET, ST_ADR_REL: phy_ctrl[FIELD_W-1:0] = addr_q;
      ST_ADR_CAP: begin
        phy_ctrl[FIELD_W-1:0] = addr_q;
        phy_ctrl[CAPA_BIT]    = 1'b1;
      end
      ST_DAT_SET, ST_DAT_REL, ST_WR_REL: phy_ctrl[FIELD_W-1:0] = wdata_q;
      ST_DAT_CAP: begin
        phy_ctrl[FIELD_W-1:0] = wdata_q;
        phy_ctrl[CAPD_BIT]    = 1'b1;
      end
      ST_WR_ON: phy_ctrl[WR_BIT] = 1'b1;
      ST_RD_ON: phy_ctrl[RD_BIT] = 1'b1;
      default:  phy_ctrl = '0;
    endcase
  end

  assign req_done  = done_q;
  assign req_err   = err_q;
  assign req_rdata = rdata_q;

  // R1: strobes are mutually exclusive
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(phy_ctrl[RD_BIT:CAPA_BIT]));

  // R5: a strobe is only withdrawn after the acknowledge was seen high
  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($fell(|phy_ctrl[RD_BIT:CAPA_BIT]) && !req_err) |-> $past(phy_stat[ACK_BIT]));

  // R6: an error leaves the PHY port quiet and never coincides with done
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_err |-> (phy_ctrl == '0) && !req_done);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_done |=> !req_done);

  // R7: read data changes only on a read capture
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q != ST_RD_ON) |=> $stable(req_rdata));

  // R8: a start while busy does not restart the sequence
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_start && (state_q != ST_IDLE) && (state_q != ST_WR_REL) && (state_q != ST_RD_REL))
      |=> (state_q != ST_ADR_SET));
endmodule

// File: tb/phy_handshake_master_tb_top.sv
`timescale 1ns/1ps
module phy_handshake_master_tb_top;
  localparam int P  = 4;
  localparam int MP = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        req_done, req_err;
  logic [15:0] req_rdata;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  always #5 clk = ~clk;

  phy_handshake_master #(.PRESCALE(P), .MAX_POLLS(MP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
    .req_err(req_err), .req_rdata(req_rdata), .phy_ctrl(phy_ctrl),
    .phy_stat(phy_stat)
  );

  // behavioural PHY responder
  logic [15:0] mem [16];
  logic [15:0] model [16];
  logic [15:0] lat_addr, lat_data;
  logic [31:0] hist;
  logic [19:0] prev_ctrl;
  logic [19:0] log_w [16];
  int          log_n;
  int          resp_lat;
  bit          mute, stuck;

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]   = 16'hC000 | 16'(i);
      model[i] = 16'hC000 | 16'(i);
    end
    hist = '0; prev_ctrl = '0; log_n = 0; resp_lat = 1;
    mute = 0; stuck = 0; lat_addr = '0; lat_data = '0;
  end

  always @(negedge clk) begin
    hist = {hist[30:0], |phy_ctrl[19:16]};
    if (phy_ctrl[16] && !prev_ctrl[16]) lat_addr = phy_ctrl[15:0];
    if (phy_ctrl[17] && !prev_ctrl[17]) lat_data = phy_ctrl[15:0];
    if (phy_ctrl[18] && !prev_ctrl[18]) mem[lat_addr[3:0]] = lat_data;
    if (phy_ctrl != prev_ctrl) begin
      if (log_n < 16) log_w[log_n] = phy_ctrl;
      log_n++;
    end
    prev_ctrl = phy_ctrl;
  end

  assign phy_stat[16]   = stuck ? 1'b1 : mute ? 1'b0 : hist[resp_lat-1];
  assign phy_stat[15:0] = mem[lat_addr[3:0]];

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vectors: {write, addr, data, latency}
  localparam logic [40:0] VEC [8] = '{
    {1'b1, 16'h0003, 16'h1234, 8'd1},
    {1'b1, 16'h0005, 16'hBEEF, 8'd7},
    {1'b0, 16'h0003, 16'h0000, 8'd2},
    {1'b1, 16'h000A, 16'h00FF, 8'd12},
    {1'b0, 16'h0005, 16'h0000, 8'd5},
    {1'b0, 16'h000A, 16'h0000, 8'd1},
    {1'b1, 16'h0003, 16'h5A5A, 8'd3},
    {1'b0, 16'h0003, 16'h0000, 8'd9}
  };

  task automatic do_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                           input int lat, input bit poke);
    logic [19:0] e [16];
    int e_n = 0;
    int dones = 0, errs = 0, seen_at = -1;
    logic [15:0] rd_at_done = '0;
    e[e_n++] = {4'h0, a};
    e[e_n++] = {4'h1, a};
    e[e_n++] = {4'h0, a};
    if (wr) begin
      e[e_n++] = {4'h0, d};
      e[e_n++] = {4'h2, d};
      e[e_n++] = {4'h0, d};
      e[e_n++] = {4'h4, 16'h0};
      e[e_n++] = {4'h0, d};
      e[e_n++] = 20'h0;
    end else begin
      e[e_n++] = {4'h8, 16'h0};
      e[e_n++] = 20'h0;
    end
    @(negedge clk);
    resp_lat = lat; log_n = 0;
    req_write = wr; req_addr = a; req_wdata = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int i = 1; i < 600; i++) begin
      @(negedge clk);
      if (poke && i == 6) begin
        req_write = 1'b0; req_addr = 16'h000F; req_start = 1'b1;
      end else begin
        req_start = 1'b0;
      end
      if (req_done) begin
        dones++;
        if (seen_at < 0) begin seen_at = i; rd_at_done = req_rdata; end
      end
      if (req_err) errs++;
      if (seen_at >= 0 && i > seen_at + 20) break;
    end
    chk(dones == 1, "R7 done count", dones, 1);
    chk(errs == 0, "R6 no error", errs, 0);
    chk(log_n == e_n, wr ? "R3 sequence length" : "R4 sequence length", log_n, e_n);
    for (int k = 0; k < e_n && k < log_n; k++)
      chk(log_w[k] == e[k], (k < 3) ? "R2 address phase word" : (wr ? "R3 write word" : "R4 read word"),
          log_w[k], e[k]);
    if (wr) begin
      model[a[3:0]] = d;
      chk(req_rdata == rd_at_done, "R7 rdata held over write", req_rdata, rd_at_done);
    end else begin
      chk(rd_at_done == model[a[3:0]], "R4 read data", rd_at_done, model[a[3:0]]);
      chk(req_rdata == rd_at_done, "R7 rdata stable after done", req_rdata, rd_at_done);
    end
  endtask

  task automatic do_timeout(input bit stk, input int exp_lat);
    int got = -1, dones = 0;
    logic [19:0] ctrl_at = 20'hFFFFF;
    @(negedge clk);
    mute = !stk; stuck = stk; log_n = 0;
    req_write = 1'b1; req_addr = 16'h0007; req_wdata = 16'h0077; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      if (req_done) dones++;
      if (req_err && got < 0) begin got = i; ctrl_at = phy_ctrl; end
      if (got >= 0 && i > got + 3) break;
    end
    chk(got == exp_lat, stk ? "R6 timeout latency ack stuck high" : "R6 timeout latency no ack",
        got, exp_lat);
    chk(ctrl_at == 20'h0, "R6 ctrl zero on error", ctrl_at, 0);
    chk(dones == 0, "R6 no done on timeout", dones, 0);
    chk(!req_err, "R6 error one cycle", req_err, 0);
    mute = 0; stuck = 0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_start = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(phy_ctrl == 20'h0, "R9 ctrl zero in reset", phy_ctrl, 0);
    chk(!req_done, "R9 done low in reset", req_done, 0);
    chk(!req_err, "R9 err low in reset", req_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(phy_ctrl == 20'h0, "R9 ctrl zero after reset", phy_ctrl, 0);

    for (int v = 0; v < 8; v++)
      do_access(VEC[v][40], VEC[v][39:24], VEC[v][23:8], int'(VEC[v][7:0]), 1'b0);

    // R8: second start injected mid-access
    do_access(1'b1, 16'h0009, 16'h3C3C, 4, 1'b1);
    do_access(1'b0, 16'h0009, 16'h0000, 2, 1'b0);

    // R6: no acknowledge, then acknowledge stuck high
    do_timeout(1'b0, 2 + (MP-1)*P);
    do_timeout(1'b1, 3 + (MP-1)*P);

    // R5: recovery after timeouts, longest latency within the poll window
    do_access(1'b1, 16'h000C, 16'h8001, 30, 1'b0);
    do_access(1'b0, 16'h000C, 16'h0000, 30, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule